// File: doc/BRIEF.md
# Prioritised interrupt arbiter with timed masking

This block decides which interrupt a small CPU should take next. Peripheral sources raise pulse requests that latch into per-source flags. Each source also has an enable bit and a 3-bit priority level from 1 to 7. A level of 0 turns the source off. A few trap sources sit above every user level, at levels 8 to 15, and nothing masks them. The block keeps the CPU's current priority. It offers a request to the CPU only when a candidate's level is strictly above that priority. Two other things hold back user sources: a counted masking window, and a switch that forbids nesting.

The CPU accepts a request with `int_ack`. The block then pushes the old CPU priority onto an internal save stack and raises the priority to the level it presented. `int_ret` pops the stack and puts the saved priority back. Software reaches the flags, enables, priorities and control bits through a small write port. It reads them back through a registered read port. A masking command, given as a cycle count, holds off user levels 1 to 6 for that many cycles.

Top module: `prio_intc`

## Requirements
- R1: After reset, every source priority reads 4. Enables, flags and trap flags read 0, the nesting-disable bit reads 0, the CPU priority is 0 and `irq` is low.
- R2: A user source is a candidate when its flag and enable are both set and its priority is nonzero. It is offered only when that priority is strictly greater than `cpu_prio`. `irq`, `irq_vec` and `irq_level` are registered, so they reflect the state one clock edge after it settles.
- R3: Among candidates of equal highest level, the lowest source index wins. `irq_vec` is the source index for a user source and N_SRC+j for trap j.
- R4: Trap j has level 15-j. A trap is offered whenever its flag is set and its level exceeds `cpu_prio`. The masking window and the nesting switch do not affect traps, and a trap always beats a user source.
- R5: A CPU priority of 7 blocks every user source.
- R6: A masking command with count K masks user levels 1 to 6 for the next K cycles, and level 7 sources are still offered. A new command reloads the count, and the mask ends when the count reaches zero.
- R7: `int_ack` while `irq` is high pushes the old CPU priority, loads `irq_level` into `cpu_prio`, and forces `irq` low for the next cycle. `int_ack` with `irq` low is ignored.
- R8: While the nesting-disable bit is set, accepting a user source sets `cpu_prio` to 7. While the save stack is non-empty in that mode, no user source is offered, even after software lowers the CPU priority.
- R9: `int_ret` pops the most recent saved priority into `cpu_prio`. When the stack is empty, `int_ret` changes nothing.
- R10: A source flag set by a pulse on `src_set` stays set until software clears it, and a set pulse wins over a clear in the same cycle. A flag left set is offered again as soon as a return drops the CPU priority below its level.
- R11: A trap flag set by `trap_set` stays set through entry and return. Only a write-one-to-clear to its register bit clears it.
- R12: The save stack holds 8 entries. An accept while it holds 8 still loads the new priority, but it saves nothing, leaves the depth at 8 and sets trap flag 0.
- R13: Register map (`wr_addr`/`rd_addr`):
  - 0: bit 0 is the nesting-disable bit.
  - 1: CPU priority; a write loads bits 2:0, unless an accept or return occurs in the same cycle.
  - 2: source flags, write-one-to-clear.
  - 3: enables.
  - 4: trap flags, write-one-to-clear.
  - 5: stack depth, read-only.
  - 8+i: priority of source i in bits 2:0.

  `rd_data` shows the addressed value one edge after `rd_addr` is presented.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| src_set | input | N_SRC | Per-source request pulses that set flags |
| trap_set | input | N_TRAP | Per-trap event pulses that set trap flags |
| wr_en | input | 1 | Register write strobe |
| wr_addr | input | AW | Register write address |
| wr_data | input | DW | Register write data |
| rd_addr | input | AW | Register read address |
| rd_data | output | DW | Registered read data |
| mask_load | input | 1 | Start or reload the timed mask |
| mask_cycles | input | CW | Length of the mask window in cycles |
| irq | output | 1 | Interrupt offered to the CPU |
| irq_vec | output | VEC_W | Index of the offered source |
| irq_level | output | 4 | CPU priority to load on entry |
| int_ack | input | 1 | CPU accepts the offered interrupt |
| int_ret | input | 1 | CPU returns from a handler |
| cpu_prio | output | 4 | Current CPU priority |

## Verification
The hardest state to reach is a full save stack. User levels give only seven strictly rising entries, so the stimulus steps through sources with priorities 1 to 7 one at a time and accepts each. It then raises two traps of rising level, and the second accept lands on a full stack. A reference model in the bench tracks flags, the stack and the mask count every cycle. It compares all outputs as the bench also reloads the masking window before it expires and lowers the CPU priority under the nesting switch.

// File: rtl/intc_pkg.sv
package intc_pkg;
  typedef logic [3:0] lvl_t;

  localparam int unsigned ADR_CTRL  = 0;
  localparam int unsigned ADR_CPL   = 1;
  localparam int unsigned ADR_FLAG  = 2;
  localparam int unsigned ADR_EN    = 3;
  localparam int unsigned ADR_TRAP  = 4;
  localparam int unsigned ADR_DEPTH = 5;
  localparam int unsigned ADR_PRIO  = 8;

  localparam lvl_t LVL_USER_TOP = 4'd7;
  localparam logic [2:0] PRIO_RESET = 3'd4;

  function automatic lvl_t trap_level(input int unsigned idx);
    return lvl_t'(15 - idx);
  endfunction
endpackage

// File: rtl/intc_srcregs.sv
module intc_srcregs
  import intc_pkg::*;
#(
  parameter int N_SRC   = 8,
  parameter int N_TRAP  = 4,
  parameter int AW      = 5,
  parameter int DW      = 16,
  parameter int DEPTH_W = 4
) (
  input  logic                 clk,
  input  logic                 rst,
  input  logic [N_SRC-1:0]     src_set,
  input  logic [N_TRAP-1:0]    trap_set,
  input  logic                 ovf_set,
  input  logic                 wr_en,
  input  logic [AW-1:0]        wr_addr,
  input  logic [DW-1:0]        wr_data,
  input  logic [AW-1:0]        rd_addr,
  input  lvl_t                 cpu_prio,
  input  logic [DEPTH_W-1:0]   depth,
  output logic [N_SRC-1:0]     flags,
  output logic [N_SRC-1:0]     enables,
  output logic [3*N_SRC-1:0]   prio_flat,
  output logic [N_TRAP-1:0]    trap_flags,
  output logic                 nest_dis,
  output logic [DW-1:0]        rd_data
);
  logic [2:0]        prio_q [N_SRC];
  logic [N_SRC-1:0]  flag_q, en_q, flag_clr;
  logic [N_TRAP-1:0] trap_q, trap_clr, trap_hw;
  logic              nest_q;
  logic [DW-1:0]     rd_mux, rd_q;

  function automatic logic hit(input int unsigned a);
    return wr_en && (wr_addr == AW'(a));
  endfunction

  assign flag_clr = hit(ADR_FLAG) ? wr_data[N_SRC-1:0]  : '0;
  assign trap_clr = hit(ADR_TRAP) ? wr_data[N_TRAP-1:0] : '0;
  assign trap_hw  = trap_set | {{(N_TRAP-1){1'b0}}, ovf_set};

  always_ff @(posedge clk) begin
    if (rst) begin
      flag_q <= '0;
      en_q   <= '0;
      trap_q <= '0;
      nest_q <= 1'b0;
      for (int i = 0; i < N_SRC; i++) prio_q[i] <= PRIO_RESET;
    end else begin
      flag_q <= (flag_q & ~flag_clr) | src_set;
      trap_q <= (trap_q & ~trap_clr) | trap_hw;
      if (hit(ADR_EN))   en_q   <= wr_data[N_SRC-1:0];
      if (hit(ADR_CTRL)) nest_q <= wr_data[0];
      for (int i = 0; i < N_SRC; i++)
        if (hit(ADR_PRIO + i)) prio_q[i] <= wr_data[2:0];
    end
  end

  always_comb begin
    rd_mux = '0;
    case (rd_addr)
      AW'(ADR_CTRL):  rd_mux[0]              = nest_q;
      AW'(ADR_CPL):   rd_mux[3:0]            = cpu_prio;
      AW'(ADR_FLAG):  rd_mux[N_SRC-1:0]      = flag_q;
      AW'(ADR_EN):    rd_mux[N_SRC-1:0]      = en_q;
      AW'(ADR_TRAP):  rd_mux[N_TRAP-1:0]     = trap_q;
      AW'(ADR_DEPTH): rd_mux[DEPTH_W-1:0]    = depth;
      default: ;
    endcase
    for (int i = 0; i < N_SRC; i++)
      if (rd_addr == AW'(ADR_PRIO + i)) rd_mux[2:0] = prio_q[i];
  end

  always_ff @(posedge clk) begin
    if (rst) rd_q <= '0;
    else     rd_q <= rd_mux;
  end

  for (genvar g = 0; g < N_SRC; g++) begin : g_flat
    assign prio_flat[3*g +: 3] = prio_q[g];
  end

  assign flags      = flag_q;
  assign enables    = en_q;
  assign trap_flags = trap_q;
  assign nest_dis   = nest_q;
  assign rd_data    = rd_q;

  // R10
  flag_sticky_chk: assert property (@(posedge clk) disable iff (rst)
    flag_q[0] && !flag_clr[0] |=> flag_q[0]);
  // R11
  trap_sticky_chk: assert property (@(posedge clk) disable iff (rst)
    trap_q[0] && !trap_clr[0] |=> trap_q[0]);
endmodule

// File: rtl/intc_mask_timer.sv
module intc_mask_timer #(
  parameter int CW = 8
) (
  input  logic          clk,
  input  logic          rst,
  input  logic          load,
  input  logic [CW-1:0] load_val,
  output logic          active
);
  logic [CW-1:0] cnt_q;

  always_ff @(posedge clk) begin
    if (rst)                cnt_q <= '0;
    else if (load)          cnt_q <= load_val;
    else if (cnt_q != '0)   cnt_q <= cnt_q - 1'b1;
  end

  assign active = (cnt_q != '0);

  // R6
  mask_reload_chk: assert property (@(posedge clk) disable iff (rst)
    load && (load_val != '0) |=> active);
endmodule

// File: rtl/intc_arbiter.sv
module intc_arbiter
  import intc_pkg::*;
#(
  parameter int N_SRC  = 8,
  parameter int N_TRAP = 4,
  parameter int VEC_W  = 4
) (
  input  logic [N_SRC-1:0]   flags,
  input  logic [N_SRC-1:0]   enables,
  input  logic [3*N_SRC-1:0] prio_flat,
  input  logic [N_TRAP-1:0]  trap_flags,
  input  lvl_t               cpu_prio,
  input  logic               mask_low,
  input  logic               nest_dis,
  input  logic               nest_block,
  output logic               hit,
  output logic [VEC_W-1:0]   vec,
  output lvl_t               level
);
  logic             u_hit, t_hit;
  lvl_t             u_lvl, t_lvl;
  logic [VEC_W-1:0] u_idx, t_idx;

  always_comb begin
    u_hit = 1'b0;
    u_lvl = '0;
    u_idx = '0;
    for (int i = N_SRC - 1; i >= 0; i--) begin
      lvl_t l;
      logic ok;
      l  = {1'b0, prio_flat[3*i +: 3]};
      ok = flags[i] && enables[i] && (l != '0) && (l > cpu_prio)
           && !(mask_low && (l < LVL_USER_TOP)) && !nest_block;
      if (ok && (!u_hit || l >= u_lvl)) begin
        u_hit = 1'b1;
        u_lvl = l;
        u_idx = VEC_W'(i);
      end
    end
  end

  always_comb begin
    t_hit = 1'b0;
    t_lvl = '0;
    t_idx = '0;
    for (int j = N_TRAP - 1; j >= 0; j--) begin
      if (trap_flags[j] && (trap_level(j) > cpu_prio)) begin
        t_hit = 1'b1;
        t_lvl = trap_level(j);
        t_idx = VEC_W'(N_SRC + j);
      end
    end
  end

  always_comb begin
    hit   = t_hit || u_hit;
    vec   = '0;
    level = '0;
    if (t_hit) begin
      vec   = t_idx;
      level = t_lvl;
    end else if (u_hit) begin
      vec   = u_idx;
      level = nest_dis ? LVL_USER_TOP : u_lvl;
    end
  end
endmodule

// File: rtl/intc_ctx.sv
module intc_ctx
  import intc_pkg::*;
#(
  parameter int DEPTH   = 8,
  parameter int DEPTH_W = 4
) (
  input  logic               clk,
  input  logic               rst,
  input  logic               take,
  input  logic               ret,
  input  logic               cpl_wr,
  input  logic [2:0]         cpl_val,
  input  lvl_t               new_level,
  output lvl_t               cpu_prio,
  output logic [DEPTH_W-1:0] depth,
  output logic               ovf
);
  localparam int PTR_W = (DEPTH > 1) ? $clog2(DEPTH) : 1;

  lvl_t               stk [DEPTH];
  lvl_t               cpu_q;
  logic [DEPTH_W-1:0] depth_q;
  logic               full, empty;
  logic [PTR_W-1:0]   push_ptr, pop_ptr;

  assign full     = (depth_q == DEPTH_W'(DEPTH));
  assign empty    = (depth_q == '0);
  assign push_ptr = PTR_W'(depth_q);
  assign pop_ptr  = PTR_W'(depth_q - 1'b1);
  assign ovf      = take && full;

  always_ff @(posedge clk) begin
    if (take && !full) stk[push_ptr] <= cpu_q;
  end

  always_ff @(posedge clk) begin
    if (rst) begin
      cpu_q   <= '0;
      depth_q <= '0;
    end else if (take) begin
      cpu_q <= new_level;
      if (!full) depth_q <= depth_q + 1'b1;
    end else if (ret && !empty) begin
      cpu_q   <= stk[pop_ptr];
      depth_q <= depth_q - 1'b1;
    end else if (cpl_wr) begin
      cpu_q <= {1'b0, cpl_val};
    end
  end

  assign cpu_prio = cpu_q;
  assign depth    = depth_q;

  // R12
  depth_bound_chk: assert property (@(posedge clk) disable iff (rst)
    depth_q <= DEPTH_W'(DEPTH));
  // R12
  full_hold_chk: assert property (@(posedge clk) disable iff (rst)
    take && full |=> depth_q == DEPTH_W'(DEPTH));
  // R9
  empty_ret_chk: assert property (@(posedge clk) disable iff (rst)
    ret && !take && empty |=> $stable(cpu_q));
endmodule

// File: rtl/prio_intc.sv
module prio_intc
  import intc_pkg::*;
#(
  parameter int N_SRC  = 8,
  parameter int N_TRAP = 4,
  parameter int AW     = 5,
  parameter int DW     = 16,
  parameter int CW     = 8,
  parameter int DEPTH  = 8,
  parameter int VEC_W  = $clog2(N_SRC + N_TRAP)
) (
  input  logic              clk,
  input  logic              rst,
  input  logic [N_SRC-1:0]  src_set,
  input  logic [N_TRAP-1:0] trap_set,
  input  logic              wr_en,
  input  logic [AW-1:0]     wr_addr,
  input  logic [DW-1:0]     wr_data,
  input  logic [AW-1:0]     rd_addr,
  output logic [DW-1:0]     rd_data,
  input  logic              mask_load,
  input  logic [CW-1:0]     mask_cycles,
  output logic              irq,
  output logic [VEC_W-1:0]  irq_vec,
  output logic [3:0]        irq_level,
  input  logic              int_ack,
  input  logic              int_ret,
  output logic [3:0]        cpu_prio
);
  localparam int DEPTH_W = $clog2(DEPTH + 1);

  logic [N_SRC-1:0]   flags, enables;
  logic [3*N_SRC-1:0] prio_flat;
  logic [N_TRAP-1:0]  trap_flags;
  logic               nest_dis, mask_active, ovf, take, arb_hit, cpl_wr;
  logic [DEPTH_W-1:0] depth;
  logic [VEC_W-1:0]   arb_vec, vec_q;
  lvl_t               arb_lvl, lvl_q, cpu_q;
  logic               irq_q;

  assign take   = int_ack && irq_q;
  assign cpl_wr = wr_en && (wr_addr == AW'(ADR_CPL));

  intc_srcregs #(.N_SRC(N_SRC), .N_TRAP(N_TRAP), .AW(AW), .DW(DW), .DEPTH_W(DEPTH_W)) u_regs (
    .clk(clk), .rst(rst), .src_set(src_set), .trap_set(trap_set), .ovf_set(ovf),
    .wr_en(wr_en), .wr_addr(wr_addr), .wr_data(wr_data), .rd_addr(rd_addr),
    .cpu_prio(cpu_q), .depth(depth), .flags(flags), .enables(enables),
    .prio_flat(prio_flat), .trap_flags(trap_flags), .nest_dis(nest_dis), .rd_data(rd_data)
  );

  intc_mask_timer #(.CW(CW)) u_mask (
    .clk(clk), .rst(rst), .load(mask_load), .load_val(mask_cycles), .active(mask_active)
  );

  intc_arbiter #(.N_SRC(N_SRC), .N_TRAP(N_TRAP), .VEC_W(VEC_W)) u_arb (
    .flags(flags), .enables(enables), .prio_flat(prio_flat), .trap_flags(trap_flags),
    .cpu_prio(cpu_q), .mask_low(mask_active), .nest_dis(nest_dis),
    .nest_block(nest_dis && (depth != '0)), .hit(arb_hit), .vec(arb_vec), .level(arb_lvl)
  );

  intc_ctx #(.DEPTH(DEPTH), .DEPTH_W(DEPTH_W)) u_ctx (
    .clk(clk), .rst(rst), .take(take), .ret(int_ret), .cpl_wr(cpl_wr),
    .cpl_val(wr_data[2:0]), .new_level(lvl_q), .cpu_prio(cpu_q), .depth(depth), .ovf(ovf)
  );

  always_ff @(posedge clk) begin
    if (rst) begin
      irq_q <= 1'b0;
      vec_q <= '0;
      lvl_q <= '0;
    end else begin
      irq_q <= arb_hit && !take;
      vec_q <= arb_vec;
      lvl_q <= arb_lvl;
    end
  end

  assign irq       = irq_q;
  assign irq_vec   = vec_q;
  assign irq_level = lvl_q;
  assign cpu_prio  = cpu_q;

  // R7
  ack_drop_chk: assert property (@(posedge clk) disable iff (rst)
    take |=> !irq_q);
  // R2
  level_above_cpu_chk: assert property (@(posedge clk) disable iff (rst)
    irq_q |-> lvl_q > $past(cpu_q));
  // R6
  mask_window_chk: assert property (@(posedge clk) disable iff (rst)
    irq_q && (lvl_q != '0) && (lvl_q < LVL_USER_TOP) |-> !$past(mask_active));
  // R8
  nest_block_chk: assert property (@(posedge clk) disable iff (rst)
    irq_q && $past(nest_dis) && ($past(depth) != '0) |-> vec_q >= VEC_W'(N_SRC));
endmodule

// File: tb/prio_intc_bench.sv
module prio_intc_bench;
  localparam int N = 8, T = 4, AW = 5, DW = 16, CW = 8, D = 8, VW = 4;

  logic clk = 1'b0;
  always #10 clk = ~clk;

  logic          rst = 1'b1;
  logic [N-1:0]  src_set = '0;
  logic [T-1:0]  trap_set = '0;
  logic          wr_en = 1'b0;
  logic [AW-1:0] wr_addr = '0;
  logic [DW-1:0] wr_data = '0;
  logic [AW-1:0] rd_addr = '0;
  logic [DW-1:0] rd_data;
  logic          mask_load = 1'b0;
  logic [CW-1:0] mask_cycles = '0;
  logic          irq;
  logic [VW-1:0] irq_vec;
  logic [3:0]    irq_level;
  logic          int_ack = 1'b0;
  logic          int_ret = 1'b0;
  logic [3:0]    cpu_prio;

  prio_intc u_prio_intc (
    .clk(clk), .rst(rst), .src_set(src_set), .trap_set(trap_set), .wr_en(wr_en),
    .wr_addr(wr_addr), .wr_data(wr_data), .rd_addr(rd_addr), .rd_data(rd_data),
    .mask_load(mask_load), .mask_cycles(mask_cycles), .irq(irq), .irq_vec(irq_vec),
    .irq_level(irq_level), .int_ack(int_ack), .int_ret(int_ret), .cpu_prio(cpu_prio)
  );

  int errs = 0, checks = 0;
  bit done = 0;
  string cur_req = "R1";

  // reference model state
  int m_flag[N], m_en[N], m_prio[N], m_trap[T];
  int m_nest, m_cpl, m_cnt, m_irq, m_vec, m_lvl, m_rd;
  int m_stk[$];

  task automatic chk(string req, string what, int act, int exp);
    checks++;
    if (act != exp) begin
      errs++;
      $display("FAIL %s %s actual=%0d expected=%0d", req, what, act, exp);
    end
  endtask

  function automatic int m_read(int a);
    int v = 0;
    case (a)
      0: v = m_nest;
      1: v = m_cpl;
      2: for (int i = 0; i < N; i++) v |= m_flag[i] << i;
      3: for (int i = 0; i < N; i++) v |= m_en[i] << i;
      4: for (int j = 0; j < T; j++) v |= m_trap[j] << j;
      5: v = m_stk.size();
      default: if (a >= 8 && a < 8 + N) v = m_prio[a - 8];
    endcase
    return v;
  endfunction

  task automatic m_arb(output int hit, output int vec, output int lvl);
    int best = -1;
    hit = 0; vec = 0; lvl = 0;
    for (int i = 0; i < N; i++) begin
      bit ok = m_flag[i] && m_en[i] && m_prio[i] > 0 && m_prio[i] > m_cpl
               && !(m_cnt > 0 && m_prio[i] < 7) && !(m_nest && m_stk.size() > 0);
      if (ok && (best < 0 || m_prio[i] > m_prio[best])) best = i;
    end
    if (best >= 0) begin
      hit = 1; vec = best; lvl = m_nest ? 7 : m_prio[best];
    end
    for (int j = 0; j < T; j++)
      if (m_trap[j] && (15 - j) > m_cpl) begin
        hit = 1; vec = N + j; lvl = 15 - j;
        break;
      end
  endtask

  always @(posedge clk) begin
    if (rst) begin
      for (int i = 0; i < N; i++) begin m_flag[i] = 0; m_en[i] = 0; m_prio[i] = 4; end
      for (int j = 0; j < T; j++) m_trap[j] = 0;
      m_nest = 0; m_cpl = 0; m_cnt = 0; m_irq = 0; m_vec = 0; m_lvl = 0; m_rd = 0;
      m_stk.delete();
    end else begin
      int hit, vec, lvl, nrd, take, ovf, a;
      m_arb(hit, vec, lvl);
      nrd  = m_read(int'(rd_addr));
      take = int_ack && m_irq;
      ovf  = 0;
      a    = int'(wr_addr);
      if (take) begin
        if (m_stk.size() == D) ovf = 1;
        else m_stk.push_back(m_cpl);
        m_cpl = m_lvl;
      end else if (int_ret && m_stk.size() > 0) m_cpl = m_stk.pop_back();
      else if (wr_en && a == 1) m_cpl = int'(wr_data[2:0]);
      for (int i = 0; i < N; i++) begin
        if (src_set[i]) m_flag[i] = 1;
        else if (wr_en && a == 2 && wr_data[i]) m_flag[i] = 0;
        if (wr_en && a == 3) m_en[i] = int'(wr_data[i]);
        if (wr_en && a == 8 + i) m_prio[i] = int'(wr_data[2:0]);
      end
      for (int j = 0; j < T; j++) begin
        if (trap_set[j] || (j == 0 && ovf)) m_trap[j] = 1;
        else if (wr_en && a == 4 && wr_data[j]) m_trap[j] = 0;
      end
      if (wr_en && a == 0) m_nest = int'(wr_data[0]);
      if (mask_load) m_cnt = int'(mask_cycles);
      else if (m_cnt > 0) m_cnt--;
      m_irq = hit && !take; m_vec = vec; m_lvl = lvl; m_rd = nrd;
    end
  end

  always @(negedge clk) begin
    if (!rst && !done) begin
      chk(cur_req, "model irq", int'(irq), m_irq);
      chk(cur_req, "model cpu_prio", int'(cpu_prio), m_cpl);
      chk(cur_req, "model rd_data", int'(rd_data), m_rd);
      if (m_irq) begin
        chk(cur_req, "model irq_vec", int'(irq_vec), m_vec);
        chk(cur_req, "model irq_level", int'(irq_level), m_lvl);
      end
    end
  end

  task automatic tick(int n); repeat (n) @(negedge clk); endtask
  task automatic wr(int a, int d);
    @(negedge clk); wr_en = 1; wr_addr = AW'(a); wr_data = DW'(d);
    @(negedge clk); wr_en = 0;
  endtask
  task automatic rd(int a, output int v);
    @(negedge clk); rd_addr = AW'(a);
    @(negedge clk); v = int'(rd_data);
  endtask
  task automatic pulse_src(int k);
    @(negedge clk); src_set[k] = 1'b1; @(negedge clk); src_set = '0;
  endtask
  task automatic pulse_trap(int k);
    @(negedge clk); trap_set[k] = 1'b1; @(negedge clk); trap_set = '0;
  endtask
  task automatic mask(int n);
    @(negedge clk); mask_load = 1; mask_cycles = CW'(n); @(negedge clk); mask_load = 0;
  endtask
  task automatic wait_irq();
    for (int i = 0; i < 12 && !irq; i++) @(negedge clk);
  endtask
  task automatic ack();
    @(negedge clk); int_ack = 1; @(negedge clk); int_ack = 0;
  endtask
  task automatic ret();
    @(negedge clk); int_ret = 1; @(negedge clk); int_ret = 0;
  endtask

  initial begin
    repeat (200000) @(posedge clk);
    if (!done) begin
      done = 1; errs++; checks++;
      $display("FAIL watchdog expired actual=1 expected=0");
      $display("Result: errors=%0d of %0d checks", errs, checks);
      $finish;
    end
  end

  initial begin
    int v;
    tick(3); rst = 0;
    // R1 reset state
    cur_req = "R1";
    tick(1);
    chk("R1", "irq after reset", int'(irq), 0);
    chk("R1", "cpu_prio after reset", int'(cpu_prio), 0);
    rd(8 + 3, v); chk("R1", "priority reset level", v, 4);
    rd(3, v); chk("R1", "enables after reset", v, 0);

    // R2 basic request, R13 register map
    cur_req = "R2";
    wr(3, 'h04); pulse_src(2); tick(2);
    chk("R2", "irq basic", int'(irq), 1);
    chk("R3", "vec basic", int'(irq_vec), 2);
    chk("R2", "level basic", int'(irq_level), 4);
    rd(2, v); chk("R13", "flag register", v, 'h04);
    wr(1, 4); tick(3); chk("R2", "equal priority not taken", int'(irq), 0);
    wr(1, 0); wr(2, 'h04); tick(2); chk("R2", "cleared flag", int'(irq), 0);
    wr(8 + 4, 0); wr(3, 'h10); pulse_src(4); tick(3);
    chk("R2", "priority zero never offered", int'(irq), 0);
    wr(2, 'hFF);

    // R3 tie break
    cur_req = "R3";
    wr(3, 'h22); pulse_src(5); pulse_src(1); tick(2);
    chk("R3", "tie lowest index", int'(irq_vec), 1);
    wr(8 + 5, 5); tick(3);
    chk("R3", "higher level wins", int'(irq_vec), 5);
    wr(2, 'hFF);

    // R5 CPU priority 7 blocks users
    cur_req = "R5";
    wr(3, 'hFF); wr(8 + 6, 7); wr(1, 7); pulse_src(6); tick(3);
    chk("R5", "cpu 7 blocks level 7", int'(irq), 0);
    wr(1, 6); tick(3);
    chk("R2", "level 7 above cpu 6", int'(irq_vec), 6);
    wr(1, 0); wr(2, 'hFF);

    // R6 timed mask
    cur_req = "R6";
    wr(8 + 3, 6); mask(20); pulse_src(3); tick(3);
    chk("R6", "level 6 masked", int'(irq), 0);
    pulse_src(6); tick(2);
    chk("R6", "level 7 passes mask", int'(irq_vec), 6);
    wr(2, 'h40); tick(20);
    chk("R6", "mask expired", int'(irq_vec), 3);
    chk("R6", "mask expired irq", int'(irq), 1);
    mask(10); tick(4); mask(10); tick(7);
    chk("R6", "reload extends mask", int'(irq), 0);
    tick(6);
    chk("R6", "reloaded mask expired", int'(irq), 1);
    wr(2, 'hFF);

    // R4 traps ignore cpu 7 and mask; R11 sticky trap flags
    cur_req = "R4";
    wr(1, 7); mask(40); pulse_trap(2); tick(2);
    chk("R4", "trap vector", int'(irq_vec), N + 2);
    chk("R4", "trap level", int'(irq_level), 13);
    cur_req = "R11";
    tick(5); chk("R11", "trap flag persists", int'(irq), 1);
    wr(4, 'h04); tick(2);
    chk("R11", "trap cleared by write", int'(irq), 0);
    rd(4, v); chk("R11", "trap register", v, 0);
    wr(1, 0); tick(40);

    // R7 entry, R9 return, R10 re-request
    cur_req = "R7";
    pulse_src(2); wait_irq(); ack();
    chk("R7", "irq dropped after ack", int'(irq), 0);
    chk("R7", "cpu priority loaded", int'(cpu_prio), 4);
    pulse_src(6); wait_irq();
    chk("R7", "preempting level 7", int'(irq_vec), 6);
    ack(); tick(1);
    chk("R7", "nested cpu priority", int'(cpu_prio), 7);
    cur_req = "R10";
    ret(); tick(1);
    chk("R9", "pop restores 4", int'(cpu_prio), 4);
    chk("R10", "left flag re-requested", int'(irq_vec), 6);
    wr(2, 'h40); ret(); tick(2);
    chk("R10", "outer flag re-requested", int'(irq_vec), 2);
    wr(2, 'hFF); cur_req = "R9";
    ret(); tick(2);
    chk("R9", "empty return ignored", int'(cpu_prio), 0);

    // R8 nesting disabled
    cur_req = "R8";
    wr(0, 1); pulse_src(2); wait_irq();
    chk("R8", "entry level forced to 7", int'(irq_level), 7);
    ack(); tick(1);
    chk("R8", "cpu 7 under nest disable", int'(cpu_prio), 7);
    wr(1, 0); pulse_src(6); tick(4);
    chk("R8", "no user preemption", int'(irq), 0);
    pulse_trap(1); tick(2);
    chk("R4", "trap preempts under nest disable", int'(irq_vec), N + 1);
    ack(); wr(4, 'hF); wr(2, 'hFF); ret(); ret(); wr(0, 0); tick(2);
    chk("R8", "unwound", int'(cpu_prio), 0);

    // R12 stack overflow
    cur_req = "R12";
    for (int k = 0; k < 7; k++) wr(8 + k, k + 1);
    wr(3, 'hFF);
    for (int k = 0; k < 7; k++) begin pulse_src(k); wait_irq(); ack(); end
    pulse_trap(3); wait_irq(); ack();
    rd(5, v); chk("R12", "stack full", v, 8);
    pulse_trap(2); wait_irq(); ack(); tick(1);
    chk("R12", "priority loaded on overflow", int'(cpu_prio), 13);
    rd(5, v); chk("R12", "depth held at 8", v, 8);
    rd(4, v); chk("R12", "overflow trap flag", v & 1, 1);
    chk("R12", "overflow trap offered", int'(irq_vec), N);
    wr(4, 'hF); wr(2, 'hFF);
    for (int k = 0; k < 8; k++) ret();
    tick(2);
    chk("R9", "full unwind", int'(cpu_prio), 0);
    rd(5, v); chk("R9", "depth empty", v, 0);

    done = 1;
    $display("Result: errors=%0d of %0d checks", errs, checks);
    $finish;
  end
endmodule